// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms memory addresses for a 16-bit processor whose memory is divided into segments. From an addressing-form select, the base registers (BX, BP), the index registers (SI, DI), a displacement of none, one byte or one word, and an optional segment override, it computes the 16-bit effective address. It then picks a segment register and produces the 20-bit physical address, which is the segment value times sixteen plus the effective address.

Alongside the operand path it provides helper addresses for the stack and for the interrupt vector table. For the stack it gives the push address and new stack pointer, and the pop address and stack pointer after the pop. For a given interrupt type code it gives the physical addresses of that vector's offset word and segment word. Every result passes through a single register stage, so each output is valid one clock after its inputs are applied.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals `seg_base` shifted left four bits plus `ea`, with the sum taken modulo 2^20.
- R2: `disp_size` selects the displacement: 0 = none, 1 = byte `disp[7:0]` sign-extended from bit 7 (with `disp[15:8]` ignored), 2 = word `disp[15:0]`, and 3 = none.
- R3: `base_sel` adds 0 = nothing, 1 = BX, 2 = BP, 3 = nothing. `index_sel` adds 0 = nothing, 1 = SI, 2 = DI, 3 = nothing. `ea` is base + index + displacement, modulo 2^16.
- R4: Segment codes are 0 = data, 1 = stack, 2 = code, 3 = extra. With no override, the segment is stack when `base_sel` = 2 (BP) and data otherwise.
- R5: When `ovr_valid` is 1, `seg_sel` takes `ovr_seg` and the default choice is ignored.
- R6: `seg_base` equals the segment register named by `seg_sel`.
- R7: `push_sp` = `sp` − 2 modulo 2^16, and `push_addr` = stack segment × 16 + `push_sp` modulo 2^20.
- R8: `pop_addr` = stack segment × 16 + `sp` modulo 2^20, and `pop_sp` = `sp` + 2 modulo 2^16.
- R9: `ivt_off_addr` = `vec_type` × 4 and `ivt_seg_addr` = `vec_type` × 4 + 2.
- R10: All outputs update on the rising clock edge after their inputs change. An active-low asynchronous `rst_n` clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_sel | input | 2 | Base register select |
| index_sel | input | 2 | Index register select |
| disp_size | input | 2 | Displacement size select |
| disp | input | 16 | Displacement, low byte in [7:0] |
| bx | input | 16 | BX base register value |
| bp | input | 16 | BP base register value |
| si | input | 16 | SI index register value |
| di | input | 16 | DI index register value |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| seg_ds | input | 16 | Data segment register |
| seg_ss | input | 16 | Stack segment register |
| seg_cs | input | 16 | Code segment register |
| seg_es | input | 16 | Extra segment register |
| sp | input | 16 | Stack pointer |
| vec_type | input | 8 | Interrupt type code |
| ea | output | 16 | Effective address |
| seg_sel | output | 2 | Chosen segment code |
| seg_base | output | 16 | Chosen segment value |
| phys_addr | output | 20 | Operand physical address |
| push_addr | output | 20 | Physical address of a push |
| push_sp | output | 16 | Stack pointer after a push |
| pop_addr | output | 20 | Physical address of a pop |
| pop_sp | output | 16 | Stack pointer after a pop |
| ivt_off_addr | output | 20 | Vector offset word address |
| ivt_seg_addr | output | 20 | Vector segment word address |

## Verification
The hardest cases to reach are the wrap-arounds. In these, a negative byte displacement or a base near 0xFFFF carries past bit 15 of the effective address, or a segment near 0xFFFF carries past bit 19 of the physical address. They only appear when register values, the displacement and the segment are chosen together. The stimulus table therefore pairs large base values with positive displacements and small index values with negative byte displacements. Directed tests set a segment of 0xFFFF, and set the stack pointer to 0x0000 and 0xFFFE, to force each carry out.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int AW = 16,
  parameter int SH = 4,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    base_sel,
  input  logic [1:0]    index_sel,
  input  logic [1:0]    disp_size,
  input  logic [AW-1:0] disp,
  input  logic [AW-1:0] bx,
  input  logic [AW-1:0] bp,
  input  logic [AW-1:0] si,
  input  logic [AW-1:0] di,
  input  logic          ovr_valid,
  input  logic [1:0]    ovr_seg,
  input  logic [AW-1:0] seg_ds,
  input  logic [AW-1:0] seg_ss,
  input  logic [AW-1:0] seg_cs,
  input  logic [AW-1:0] seg_es,
  input  logic [AW-1:0] sp,
  input  logic [TW-1:0] vec_type,
  output logic [AW-1:0] ea,
  output logic [1:0]    seg_sel,
  output logic [AW-1:0] seg_base,
  output logic [AW+SH-1:0] phys_addr,
  output logic [AW+SH-1:0] push_addr,
  output logic [AW-1:0] push_sp,
  output logic [AW+SH-1:0] pop_addr,
  output logic [AW-1:0] pop_sp,
  output logic [AW+SH-1:0] ivt_off_addr,
  output logic [AW+SH-1:0] ivt_seg_addr
);
  localparam int PW = AW + SH;
  localparam int HB = AW / 2;
  localparam logic [1:0] SEG_DATA  = 2'd0;
  localparam logic [1:0] SEG_STACK = 2'd1;
  localparam logic [1:0] SEG_CODE  = 2'd2;
  localparam logic [1:0] SEG_EXTRA = 2'd3;

  logic [AW-1:0] base_v, idx_v, disp_v, ea_c, segv_c, push_sp_c;
  logic [1:0]    sel_c;
  logic [PW-1:0] ss_sh, phys_c, ivt_c;

  always_comb begin
    case (base_sel)
      2'd1:    base_v = bx;
      2'd2:    base_v = bp;
      default: base_v = '0;
    endcase
    case (index_sel)
      2'd1:    idx_v = si;
      2'd2:    idx_v = di;
      default: idx_v = '0;
    endcase
    case (disp_size)
      2'd1:    disp_v = {{HB{disp[HB-1]}}, disp[HB-1:0]};
      2'd2:    disp_v = disp;
      default: disp_v = '0;
    endcase
  end

  assign ea_c  = base_v + idx_v + disp_v;
  assign sel_c = ovr_valid ? ovr_seg : ((base_sel == 2'd2) ? SEG_STACK : SEG_DATA);

  always_comb begin
    case (sel_c)
      SEG_DATA:  segv_c = seg_ds;
      SEG_STACK: segv_c = seg_ss;
      SEG_CODE:  segv_c = seg_cs;
      SEG_EXTRA: segv_c = seg_es;
      default:   segv_c = seg_ds;
    endcase
  end

  assign phys_c    = {segv_c, {SH{1'b0}}} + {{SH{1'b0}}, ea_c};
  assign ss_sh     = {seg_ss, {SH{1'b0}}};
  assign push_sp_c = sp - AW'(2);
  assign ivt_c     = {{(PW-TW-2){1'b0}}, vec_type, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea           <= '0;
      seg_sel      <= '0;
      seg_base     <= '0;
      phys_addr    <= '0;
      push_addr    <= '0;
      push_sp      <= '0;
      pop_addr     <= '0;
      pop_sp       <= '0;
      ivt_off_addr <= '0;
      ivt_seg_addr <= '0;
    end else begin
      ea           <= ea_c;
      seg_sel      <= sel_c;
      seg_base     <= segv_c;
      phys_addr    <= phys_c;
      push_addr    <= ss_sh + {{SH{1'b0}}, push_sp_c};
      push_sp      <= push_sp_c;
      pop_addr     <= ss_sh + {{SH{1'b0}}, sp};
      pop_sp       <= sp + AW'(2);
      ivt_off_addr <= ivt_c;
      ivt_seg_addr <= ivt_c + PW'(2);
    end
  end
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ovr_valid,
  input logic [1:0]  ovr_seg,
  input logic [1:0]  base_sel,
  input logic [15:0] seg_cs,
  input logic [15:0] ea,
  input logic [1:0]  seg_sel,
  input logic [15:0] seg_base,
  input logic [19:0] phys_addr,
  input logic [15:0] push_sp,
  input logic [15:0] pop_sp,
  input logic [19:0] ivt_off_addr,
  input logic [19:0] ivt_seg_addr
);
  AST_PHYS_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[3:0] == ea[3:0]); // R1

  AST_STACK_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_valid && base_sel == 2'd2) |=> seg_sel == 2'd1); // R4

  AST_OVERRIDE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_valid |=> seg_sel == $past(ovr_seg)); // R5

  AST_CODE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_valid && ovr_seg == 2'd2) |=> seg_base == $past(seg_cs)); // R6

  AST_STACK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pop_sp - push_sp) == 16'd4); // R7

  AST_VEC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ivt_seg_addr - ivt_off_addr == 20'd2 &&
                      ivt_off_addr[1:0] == 2'b00 && ivt_off_addr < 20'h400)); // R9
endmodule

bind seg_addr_gen seg_addr_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
  .base_sel(base_sel), .seg_cs(seg_cs), .ea(ea), .seg_sel(seg_sel),
  .seg_base(seg_base), .phys_addr(phys_addr), .push_sp(push_sp),
  .pop_sp(pop_sp), .ivt_off_addr(ivt_off_addr), .ivt_seg_addr(ivt_seg_addr)
);

// File: tb/seg_addr_gen_test.sv
`timescale 1ns/1ps
module seg_addr_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] base_sel = '0, index_sel = '0, disp_size = '0, ovr_seg = '0;
  logic ovr_valid = 1'b0;
  logic [15:0] disp = '0, bx = '0, bp = '0, si = '0, di = '0, sp = '0;
  logic [15:0] seg_ds = '0, seg_ss = '0, seg_cs = '0, seg_es = '0;
  logic [7:0] vec_type = '0;
  logic [15:0] ea, seg_base, push_sp, pop_sp;
  logic [1:0] seg_sel;
  logic [19:0] phys_addr, push_addr, pop_addr, ivt_off_addr, ivt_seg_addr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seg_addr_gen uut (.*);

  typedef struct packed {
    logic [1:0] b, x, d;
    logic ov;
    logic [1:0] os;
    logic [15:0] bx, bp, si, di, disp, e;
    logic [1:0] s;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0,2'd0,2'd2,1'b0,2'd0,16'h1100,16'h2200,16'h0030,16'h0400,16'h5678,16'h5678,2'd0},
    '{2'd0,2'd1,2'd0,1'b0,2'd0,16'h1100,16'h2200,16'h0030,16'h0400,16'h9999,16'h0030,2'd0},
    '{2'd0,2'd2,2'd1,1'b0,2'd0,16'h1100,16'h2200,16'h0030,16'h0400,16'hAB80,16'h0380,2'd0},
    '{2'd0,2'd1,2'd1,1'b0,2'd0,16'h1100,16'h2200,16'h0030,16'h0400,16'hFF7F,16'h00AF,2'd0},
    '{2'd1,2'd1,2'd2,1'b0,2'd0,16'h1100,16'h2200,16'h0030,16'h0400,16'h1000,16'h2130,2'd0},
    '{2'd2,2'd0,2'd1,1'b0,2'd0,16'h1100,16'h2200,16'h0030,16'h0400,16'h5500,16'h2200,2'd1},
    '{2'd2,2'd2,2'd2,1'b0,2'd0,16'h1100,16'h2200,16'h0030,16'h0400,16'h0010,16'h2610,2'd1},
    '{2'd1,2'd0,2'd2,1'b0,2'd0,16'hFFF0,16'h2200,16'h0030,16'h0400,16'h0020,16'h0010,2'd0},
    '{2'd2,2'd0,2'd1,1'b1,2'd0,16'h1100,16'h2200,16'h0030,16'h0400,16'h0004,16'h2204,2'd0},
    '{2'd1,2'd0,2'd0,1'b1,2'd3,16'h1100,16'h2200,16'h0030,16'h0400,16'h0000,16'h1100,2'd3},
    '{2'd0,2'd1,2'd0,1'b1,2'd2,16'h1100,16'h2200,16'h0030,16'h0400,16'h0000,16'h0030,2'd2},
    '{2'd0,2'd1,2'd3,1'b0,2'd0,16'h1100,16'h2200,16'h0030,16'h0400,16'h1234,16'h0030,2'd0},
    '{2'd3,2'd3,2'd2,1'b0,2'd0,16'h1100,16'h2200,16'h0030,16'h0400,16'h0042,16'h0042,2'd0}
  };

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] segval(input logic [1:0] s);
    case (s)
      2'd0: return seg_ds;
      2'd1: return seg_ss;
      2'd2: return seg_cs;
      default: return seg_es;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    seg_ds = 16'h1234; seg_ss = 16'h2000; seg_cs = 16'hF000; seg_es = 16'h0800;
    bx = 16'h1100; si = 16'h0030; disp_size = 2'd2; disp = 16'h0100; sp = 16'h0100; vec_type = 8'h21;
    repeat (3) @(negedge clk);
    // R10 reset clears all outputs
    chk("R10 reset ea", {4'h0, ea}, 20'h0);
    chk("R10 reset phys", phys_addr, 20'h0);
    chk("R10 reset push", push_addr, 20'h0);
    chk("R10 reset ivt", ivt_seg_addr, 20'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      base_sel = VECS[i].b; index_sel = VECS[i].x; disp_size = VECS[i].d;
      ovr_valid = VECS[i].ov; ovr_seg = VECS[i].os;
      bx = VECS[i].bx; bp = VECS[i].bp; si = VECS[i].si; di = VECS[i].di; disp = VECS[i].disp;
      @(negedge clk);
      chk($sformatf("R2 R3 ea vec %0d", i), {4'h0, ea}, {4'h0, VECS[i].e});
      chk($sformatf("R4 R5 seg_sel vec %0d", i), {18'h0, seg_sel}, {18'h0, VECS[i].s});
      chk($sformatf("R6 seg_base vec %0d", i), {4'h0, seg_base}, {4'h0, segval(VECS[i].s)});
      chk($sformatf("R1 phys vec %0d", i), phys_addr, {segval(VECS[i].s), 4'h0} + {4'h0, VECS[i].e});
    end

    // R1 wrap past bit 19
    @(negedge clk);
    seg_ds = 16'hFFFF; base_sel = 2'd0; index_sel = 2'd0; disp_size = 2'd2; disp = 16'h0020; ovr_valid = 1'b0;
    @(negedge clk);
    chk("R1 phys wrap", phys_addr, 20'h00010);

    // R10 latency: output holds until the next edge
    disp = 16'h0030;
    #1;
    chk("R10 hold before edge", {4'h0, ea}, 20'h00020);
    @(negedge clk);
    chk("R10 update after edge", {4'h0, ea}, 20'h00030);

    // R2 byte disp, high byte ignored, negative
    disp_size = 2'd1; disp = 16'h00FF; index_sel = 2'd1; si = 16'h0000;
    @(negedge clk);
    chk("R2 byte minus one", {4'h0, ea}, 20'h0FFFF);

    // R5 override to stack on BX form
    ovr_valid = 1'b1; ovr_seg = 2'd1; base_sel = 2'd1;
    @(negedge clk);
    chk("R5 override stack", {18'h0, seg_sel}, 20'h1);

    // R7 R8 stack helpers
    sp = 16'h0100;
    @(negedge clk);
    chk("R7 push_sp", {4'h0, push_sp}, 20'h000FE);
    chk("R7 push_addr", push_addr, 20'h200FE);
    chk("R8 pop_addr", pop_addr, 20'h20100);
    chk("R8 pop_sp", {4'h0, pop_sp}, 20'h00102);
    sp = 16'h0000;
    @(negedge clk);
    chk("R7 push_sp wrap", {4'h0, push_sp}, 20'h0FFFE);
    chk("R7 push_addr wrap", push_addr, 20'h2FFFE);
    sp = 16'hFFFE;
    @(negedge clk);
    chk("R8 pop_sp wrap", {4'h0, pop_sp}, 20'h00000);
    chk("R8 pop_addr top", pop_addr, 20'h2FFFE);

    // R9 vector table
    vec_type = 8'h00;
    @(negedge clk);
    chk("R9 type 0 off", ivt_off_addr, 20'h0);
    chk("R9 type 0 seg", ivt_seg_addr, 20'h2);
    vec_type = 8'h21;
    @(negedge clk);
    chk("R9 type 21 off", ivt_off_addr, 20'h84);
    chk("R9 type 21 seg", ivt_seg_addr, 20'h86);
    vec_type = 8'hFF;
    @(negedge clk);
    chk("R9 type FF off", ivt_off_addr, 20'h3FC);
    chk("R9 type FF seg", ivt_seg_addr, 20'h3FE);

    // R10 asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1;
    chk("R10 async clear", ivt_off_addr, 20'h0);
    chk("R10 async clear sp", {4'h0, pop_sp}, 20'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule